// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block decides which interrupt a CPU core services next. Each peripheral supplies a flag bit and an enable bit per event. A source becomes pending when both bits of one of its pairs are set. Several pairs can share one source id, so all four serial events feed the serial id. Software-trap, illegal-opcode and non-maskable requests arrive as raise pulses and stay latched until they are taken.

Selection runs in tiers and is purely combinational. The software trap comes first, then the illegal-opcode trap; neither can be masked. The non-maskable request comes next and is gated by the X mask bit. While it is pending and masked, it blocks every source below it. All remaining sources are gated by the I mask bit and ranked by a writable priority-order table.

The block presents the chosen id and its vector-fetch address. When the core pulses a take request, the block registers the id. It then commands the core to set the matching mask bit and holds a busy indication for the core's fixed interrupt-entry time.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Flag/enable pair p drives a fixed source id: pairs 0-3 serial id 11, pair 4 id 12, pair 5 timer overflow id 15, pair 6 real-time id 24, pairs 7-11 output compare 1..5 ids 20..16, pairs 12-14 input capture 1..3 ids 23..21, pair 15 id 13, pair 16 id 14. A peripheral id is pending in the cycle after an edge where at least one of its pairs had flag and enable both high. Otherwise it is not pending.
- R2: The serial id 11 is pending while any one of its four pairs is active, whichever one it is.
- R3: A software trap (id 27) is selected before an illegal-opcode trap (id 28), and both are selected before everything else, regardless of the I and X inputs. Each stays latched from its raise pulse until it is taken, and is cleared at the take.
- R4: A latched non-maskable request (id 26) is selected when X is 0, and is cleared at its take. When X is 1 and it is latched, sel_valid_o is 0 even if other sources are pending.
- R5: With I at 1 and no trap or non-maskable request selectable, sel_valid_o is 0.
- R6: Remaining sources are selected by scanning order-table slots from 0 upward and taking the first slot whose id is pending. Reset loads slot k with id k, and a write on order_we_i sets one slot. Taking such a source does not clear it.
- R7: vec_addr_o equals 0xBFC0 + 2*sel_id_o when special_i is 1, and 0xFFC0 + 2*sel_id_o otherwise.
- R8: A take_i accepted at an edge makes taken_o, take_id_o and exactly one of set_x_o (id 26) or set_i_o (any other id) valid for the following cycle.
- R9: After an accepted take, busy_o is high for exactly 14 cycles. A take_i while busy_o is high is ignored.
- R10: sel_valid_o is 0 when nothing can be serviced, and a take_i then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flag_i | input | 17 | Peripheral event flags, one per pair |
| en_i | input | 17 | Peripheral event enables, one per pair |
| raise_swi_i | input | 1 | Software trap raise pulse |
| raise_ill_i | input | 1 | Illegal-opcode raise pulse |
| raise_xirq_i | input | 1 | Non-maskable request raise pulse |
| i_mask_i | input | 1 | CPU maskable-interrupt mask bit |
| x_mask_i | input | 1 | CPU non-maskable-request mask bit |
| special_i | input | 1 | Special-mode strap selecting the vector base |
| take_i | input | 1 | Core requests to take the selected interrupt |
| order_we_i | input | 1 | Priority-table write enable |
| order_slot_i | input | 5 | Priority-table slot to write |
| order_id_i | input | 5 | Source id written into the slot |
| sel_valid_o | output | 1 | A source can be serviced now |
| sel_id_o | output | 5 | Selected source id |
| vec_addr_o | output | 16 | Vector-fetch address of the selected id |
| taken_o | output | 1 | One-cycle take strobe |
| take_id_o | output | 5 | Id registered at the last take |
| set_i_o | output | 1 | Command to set the I mask bit |
| set_x_o | output | 1 | Command to set the X mask bit |
| busy_o | output | 1 | Interrupt entry in progress |

## Verification
The assertions assume that the core raises take_i only while it looks at sel_valid_o. They also assume the mask inputs follow the core's own condition codes and do not depend on set_i_o or set_x_o. The stimulus drives the mask bits, raise pulses, order writes and takes freely, but always between clock edges. Flags are sparse so that the tiers compete, and a reference priority model predicts every tier boundary, including a take landing while busy.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int NUM_SRC   = 32;
  localparam int ID_W      = $clog2(NUM_SRC);
  localparam int NUM_PAIRS = 17;

  localparam int ID_SCI  = 11;
  localparam int ID_SPI  = 12;
  localparam int ID_PAI  = 13;
  localparam int ID_PAO  = 14;
  localparam int ID_TOV  = 15;
  localparam int ID_RTI  = 24;
  localparam int ID_XIRQ = 26;
  localparam int ID_SWI  = 27;
  localparam int ID_ILL  = 28;

  typedef logic [ID_W-1:0] src_id_t;

  // source id fed by flag/enable pair p
  function automatic src_id_t pair_src(input int p);
    case (p)
      0, 1, 2, 3: return src_id_t'(ID_SCI);
      4:          return src_id_t'(ID_SPI);
      5:          return src_id_t'(ID_TOV);
      6:          return src_id_t'(ID_RTI);
      7, 8, 9, 10, 11: return src_id_t'(20 - (p - 7));
      12, 13, 14: return src_id_t'(23 - (p - 12));
      15:         return src_id_t'(ID_PAI);
      16:         return src_id_t'(ID_PAO);
      default:    return '0;
    endcase
  endfunction
endpackage

// File: rtl/ivc_pending.sv
module ivc_pending
  import ivc_pkg::*;
#(
  parameter int NPAIR = NUM_PAIRS,
  parameter int NSRC  = NUM_SRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPAIR-1:0] flag_i,
  input  logic [NPAIR-1:0] en_i,
  input  logic             raise_swi_i,
  input  logic             raise_ill_i,
  input  logic             raise_xirq_i,
  input  logic [NSRC-1:0]  clr_i,
  output logic [NSRC-1:0]  pend_o
);
  logic [NSRC-1:0] dev_act, pend_d, pend_q;

  // shared ids: OR over every active pair
  always_comb begin
    dev_act = '0;
    for (int p = 0; p < NPAIR; p++) begin
      if (flag_i[p] && en_i[p]) dev_act[pair_src(p)] = 1'b1;
    end
  end

  always_comb begin
    pend_d         = dev_act;
    pend_d[ID_SWI]  = (pend_q[ID_SWI]  & ~clr_i[ID_SWI])  | raise_swi_i;
    pend_d[ID_ILL]  = (pend_q[ID_ILL]  & ~clr_i[ID_ILL])  | raise_ill_i;
    pend_d[ID_XIRQ] = (pend_q[ID_XIRQ] & ~clr_i[ID_XIRQ]) | raise_xirq_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/ivc_order_table.sv
module ivc_order_table #(
  parameter int N = 32,
  parameter int W = $clog2(N)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [W-1:0]        slot_i,
  input  logic [W-1:0]        id_i,
  output logic [N-1:0][W-1:0] tbl_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           tbl_o[g] <= W'(g);
      else if (we_i && slot_i == W'(g))      tbl_o[g] <= id_i;
    end
  end
endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
  import ivc_pkg::*;
#(
  parameter int NSRC = NUM_SRC,
  parameter int W    = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        pend_i,
  input  logic [NSRC-1:0][W-1:0] tbl_i,
  input  logic                   i_mask_i,
  input  logic                   x_mask_i,
  output logic                   valid_o,
  output logic [W-1:0]           id_o
);
  logic          scan_hit;
  logic [W-1:0]  scan_id;

  always_comb begin
    scan_hit = 1'b0;
    scan_id  = '0;
    for (int k = 0; k < NSRC; k++) begin
      if (!scan_hit && pend_i[tbl_i[k]]) begin
        scan_hit = 1'b1;
        scan_id  = tbl_i[k];
      end
    end
  end

  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    if (pend_i[ID_SWI]) begin
      valid_o = 1'b1;
      id_o    = W'(ID_SWI);
    end else if (pend_i[ID_ILL]) begin
      valid_o = 1'b1;
      id_o    = W'(ID_ILL);
    end else if (pend_i[ID_XIRQ]) begin
      // masked non-maskable request stalls every lower tier
      valid_o = !x_mask_i;
      id_o    = x_mask_i ? '0 : W'(ID_XIRQ);
    end else if (!i_mask_i && scan_hit) begin
      valid_o = 1'b1;
      id_o    = scan_id;
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import ivc_pkg::*;
#(
  parameter int          NPAIR     = NUM_PAIRS,
  parameter int          BUSY_CYC  = 14,
  parameter int          VEC_W     = 16,
  parameter logic [15:0] BASE_NORM = 16'hFFC0,
  parameter logic [15:0] BASE_SPEC = 16'hBFC0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPAIR-1:0] flag_i,
  input  logic [NPAIR-1:0] en_i,
  input  logic             raise_swi_i,
  input  logic             raise_ill_i,
  input  logic             raise_xirq_i,
  input  logic             i_mask_i,
  input  logic             x_mask_i,
  input  logic             special_i,
  input  logic             take_i,
  input  logic             order_we_i,
  input  logic [4:0]       order_slot_i,
  input  logic [4:0]       order_id_i,
  output logic             sel_valid_o,
  output logic [4:0]       sel_id_o,
  output logic [15:0]      vec_addr_o,
  output logic             taken_o,
  output logic [4:0]       take_id_o,
  output logic             set_i_o,
  output logic             set_x_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  logic [NUM_SRC-1:0]           pend, clr;
  logic [NUM_SRC-1:0][ID_W-1:0] tbl;
  logic [CNT_W-1:0]             busy_cnt;
  logic                         accept;
  logic [VEC_W-1:0]             base;

  ivc_pending #(.NPAIR(NPAIR), .NSRC(NUM_SRC)) u_pend (
    .clk_i, .rst_ni, .flag_i, .en_i,
    .raise_swi_i, .raise_ill_i, .raise_xirq_i,
    .clr_i (clr),
    .pend_o(pend)
  );

  ivc_order_table #(.N(NUM_SRC), .W(ID_W)) u_order (
    .clk_i, .rst_ni,
    .we_i  (order_we_i),
    .slot_i(order_slot_i),
    .id_i  (order_id_i),
    .tbl_o (tbl)
  );

  ivc_arbiter #(.NSRC(NUM_SRC), .W(ID_W)) u_arb (
    .pend_i  (pend),
    .tbl_i   (tbl),
    .i_mask_i,
    .x_mask_i,
    .valid_o (sel_valid_o),
    .id_o    (sel_id_o)
  );

  assign base       = special_i ? BASE_SPEC : BASE_NORM;
  assign vec_addr_o = base + {{(VEC_W-ID_W-1){1'b0}}, sel_id_o, 1'b0};
  assign busy_o     = busy_cnt != '0;
  assign accept     = take_i && sel_valid_o && !busy_o;

  // the pending block keeps only the latched-request bits of this vector
  always_comb begin
    clr = '0;
    if (accept) clr[sel_id_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o   <= 1'b0;
      take_id_o <= '0;
      set_i_o   <= 1'b0;
      set_x_o   <= 1'b0;
      busy_cnt  <= '0;
    end else if (accept) begin
      taken_o   <= 1'b1;
      take_id_o <= sel_id_o;
      set_x_o   <= sel_id_o == ID_W'(ID_XIRQ);
      set_i_o   <= sel_id_o != ID_W'(ID_XIRQ);
      busy_cnt  <= CNT_W'(BUSY_CYC);
    end else begin
      taken_o <= 1'b0;
      set_i_o <= 1'b0;
      set_x_o <= 1'b0;
      if (busy_o) busy_cnt <= busy_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        i_mask_i,
  input logic        x_mask_i,
  input logic        special_i,
  input logic        sel_valid_o,
  input logic [4:0]  sel_id_o,
  input logic [15:0] vec_addr_o,
  input logic        taken_o,
  input logic [4:0]  take_id_o,
  input logic        set_i_o,
  input logic        set_x_o,
  input logic        busy_o
);
  a_r8_one_mask_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(set_i_o && set_x_o));
  a_r8_setx_is_xirq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_x_o |-> take_id_o == 5'd26);
  a_r8_take_sets_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> (set_i_o || set_x_o));
  a_r9_busy_after_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> busy_o);
  a_r9_no_take_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !taken_o);
  a_r4_xmask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && x_mask_i) |-> sel_id_o != 5'd26);
  a_r5_imask_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_valid_o && i_mask_i) |-> sel_id_o >= 5'd26);
  a_r7_vec_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_addr_o[15:6] == (special_i ? 10'h2FF : 10'h3FF));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .i_mask_i(i_mask_i), .x_mask_i(x_mask_i),
  .special_i(special_i), .sel_valid_o(sel_valid_o), .sel_id_o(sel_id_o),
  .vec_addr_o(vec_addr_o), .taken_o(taken_o), .take_id_o(take_id_o),
  .set_i_o(set_i_o), .set_x_o(set_x_o), .busy_o(busy_o)
);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 17;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [NP-1:0] flag_i = '0, en_i = '0;
  logic raise_swi_i = 0, raise_ill_i = 0, raise_xirq_i = 0;
  logic i_mask_i = 0, x_mask_i = 0, special_i = 0, take_i = 0, order_we_i = 0;
  logic [4:0] order_slot_i = '0, order_id_i = '0;
  logic sel_valid_o, taken_o, set_i_o, set_x_o, busy_o;
  logic [4:0] sel_id_o, take_id_o;
  logic [15:0] vec_addr_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [31:0] pm;
  logic [4:0]  ord [32];
  int          busy_m;
  logic        m_taken, m_seti, m_setx;
  logic [4:0]  m_tid;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk_i(clk), .rst_ni, .flag_i, .en_i, .raise_swi_i, .raise_ill_i,
    .raise_xirq_i, .i_mask_i, .x_mask_i, .special_i, .take_i, .order_we_i,
    .order_slot_i, .order_id_i, .sel_valid_o, .sel_id_o, .vec_addr_o,
    .taken_o, .take_id_o, .set_i_o, .set_x_o, .busy_o
  );

  function automatic int pair_to_id(input int p);
    if (p <= 3) return 11;
    if (p == 4) return 12;
    if (p == 5) return 15;
    if (p == 6) return 24;
    if (p <= 11) return 20 - (p - 7);
    if (p <= 14) return 23 - (p - 12);
    if (p == 15) return 13;
    return 14;
  endfunction

  function automatic void exp_sel(output logic v, output logic [4:0] id);
    v = 0; id = 0;
    if (pm[27]) begin v = 1; id = 27; end
    else if (pm[28]) begin v = 1; id = 28; end
    else if (pm[26]) begin v = !x_mask_i; id = x_mask_i ? 5'd0 : 5'd26; end
    else if (!i_mask_i) begin
      for (int k = 0; k < 32; k++)
        if (!v && pm[ord[k]]) begin v = 1; id = ord[k]; end
    end
  endfunction

  function automatic string tier_tag(input logic v, input logic [4:0] id);
    if (!v) return pm[26] ? "R4" : (i_mask_i ? "R5" : "R10");
    if (id >= 27) return "R3";
    if (id == 26) return "R4";
    return "R6";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    pm = '0; busy_m = 0; m_taken = 0; m_seti = 0; m_setx = 0; m_tid = 0;
    for (int k = 0; k < 32; k++) ord[k] = 5'(k);
  endtask

  // inputs already driven; check comb, advance one edge, check registers
  task automatic tick();
    logic ev; logic [4:0] eid; logic acc; logic [31:0] dev;
    logic [15:0] evec;
    #1;
    exp_sel(ev, eid);
    chk(sel_valid_o == ev, tier_tag(ev, eid), "sel_valid", sel_valid_o, ev);
    if (ev) chk(sel_id_o == eid, tier_tag(ev, eid), "sel_id", sel_id_o, eid);
    evec = (special_i ? 16'hBFC0 : 16'hFFC0) + 16'(sel_id_o) * 2;
    chk(vec_addr_o == evec, "R7", "vec_addr", vec_addr_o, evec);
    acc = take_i && ev && busy_m == 0;
    if (acc) begin
      m_taken = 1; m_tid = eid; m_setx = eid == 26; m_seti = eid != 26; busy_m = 14;
    end else begin
      m_taken = 0; m_seti = 0; m_setx = 0;
      if (busy_m > 0) busy_m--;
    end
    dev = '0;
    for (int p = 0; p < NP; p++) if (flag_i[p] && en_i[p]) dev[pair_to_id(p)] = 1;
    dev[27] = (pm[27] && !(acc && eid == 27)) || raise_swi_i;
    dev[28] = (pm[28] && !(acc && eid == 28)) || raise_ill_i;
    dev[26] = (pm[26] && !(acc && eid == 26)) || raise_xirq_i;
    pm = dev;
    if (order_we_i) ord[order_slot_i] = order_id_i;
    @(posedge clk);
    @(negedge clk);
    raise_swi_i = 0; raise_ill_i = 0; raise_xirq_i = 0; take_i = 0; order_we_i = 0;
    chk(taken_o == m_taken, "R8", "taken", taken_o, m_taken);
    if (m_taken) chk(take_id_o == m_tid, "R8", "take_id", take_id_o, m_tid);
    chk(set_i_o == m_seti, "R8", "set_i", set_i_o, m_seti);
    chk(set_x_o == m_setx, "R8", "set_x", set_x_o, m_setx);
    chk(busy_o == (busy_m != 0), "R9", "busy", busy_o, busy_m != 0);
  endtask

  task automatic drain();
    while (busy_o) tick();
  endtask

  initial begin
    int cnt;
    void'($urandom(32'h1dc0_4a17));
    model_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #1;
    chk(sel_valid_o == 0, "R10", "reset valid", sel_valid_o, 0);
    chk(busy_o == 0 && taken_o == 0, "R9", "reset busy/taken", {busy_o, taken_o}, 0);

    // R1: pair 6 enabled, SPI flag without enable must not win
    flag_i[6] = 1; en_i[6] = 1; flag_i[4] = 1;
    tick();
    chk(sel_valid_o && sel_id_o == 24, "R1", "rti id", sel_id_o, 24);
    // R2: any serial pair raises id 11
    flag_i[2] = 1; en_i[2] = 1; tick();
    chk(sel_id_o == 11, "R2", "serial via pair2", sel_id_o, 11);
    flag_i[2] = 0; flag_i[0] = 1; en_i[0] = 1; tick();
    chk(sel_id_o == 11, "R2", "serial via pair0", sel_id_o, 11);
    flag_i[0] = 0; tick();
    chk(sel_id_o == 24, "R2", "serial released", sel_id_o, 24);
    // R5
    i_mask_i = 1; tick();
    chk(sel_valid_o == 0, "R5", "I blocks", sel_valid_o, 0);
    // R4: masked non-maskable request blocks lower tiers
    raise_xirq_i = 1; x_mask_i = 1; i_mask_i = 0; tick();
    chk(sel_valid_o == 0, "R4", "X blocks all", sel_valid_o, 0);
    x_mask_i = 0; #1;
    chk(sel_id_o == 26 && vec_addr_o == 16'hFFF4, "R7", "xirq vector", vec_addr_o, 16'hFFF4);
    take_i = 1; tick();
    chk(set_x_o && !set_i_o && take_id_o == 26, "R8", "set_x on xirq", {set_x_o, set_i_o}, 2);
    chk(sel_id_o == 24, "R4", "xirq cleared", sel_id_o, 24);
    drain();
    // R3: traps ignore masks, order swi then ill
    raise_swi_i = 1; raise_ill_i = 1; i_mask_i = 1; x_mask_i = 1; tick();
    chk(sel_id_o == 27, "R3", "swi first", sel_id_o, 27);
    take_i = 1; tick();
    chk(set_i_o && !set_x_o, "R8", "set_i on swi", {set_x_o, set_i_o}, 1);
    chk(sel_id_o == 28, "R3", "ill next", sel_id_o, 28);
    take_i = 1; tick();
    chk(taken_o == 0, "R9", "take while busy", taken_o, 0);
    cnt = 0;
    while (busy_o) begin cnt++; tick(); end
    chk(cnt == 13, "R9", "busy length", cnt + 1, 14);
    take_i = 1; tick(); drain();
    chk(sel_valid_o == 0, "R3", "ill cleared, I set", sel_valid_o, 0);
    // R6: order table reprogram, take does not clear
    i_mask_i = 0; x_mask_i = 0; flag_i[1] = 1; en_i[1] = 1; tick();
    chk(sel_id_o == 11, "R6", "identity order", sel_id_o, 11);
    order_we_i = 1; order_slot_i = 0; order_id_i = 24; tick();
    chk(sel_id_o == 24, "R6", "reordered", sel_id_o, 24);
    take_i = 1; tick();
    chk(sel_valid_o && sel_id_o == 24, "R6", "persists after take", sel_id_o, 24);
    special_i = 1; #1;
    chk(vec_addr_o == 16'hBFF0, "R7", "special base", vec_addr_o, 16'hBFF0);
    drain();

    for (int c = 0; c < 4000; c++) begin
      flag_i = NP'($urandom & $urandom & $urandom);
      en_i   = NP'($urandom | $urandom);
      raise_swi_i  = ($urandom % 24) == 0;
      raise_ill_i  = ($urandom % 24) == 0;
      raise_xirq_i = ($urandom % 16) == 0;
      i_mask_i  = ($urandom % 3) == 0;
      x_mask_i  = ($urandom % 3) == 0;
      special_i = ($urandom % 5) == 0;
      take_i    = ($urandom % 3) == 0;
      order_we_i = ($urandom % 20) == 0;
      order_slot_i = 5'($urandom);
      order_id_i   = 5'($urandom);
      tick();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule